// File: doc/BRIEF.md
# Shared-Generator Multi-Channel PWM Controller

This block drives 33 PWM channels from a pool of 8 programmable waveform generators. Each generator holds a period in coarse units and a duty pair made of an on-count byte and an off-count byte. Each channel holds a 4-bit mapping nibble that picks one generator and enables the channel. Channels 0 to 15 leave the block as direct pins. Channels 16 to 32 leave as level values for an external serial output stage. Many channels may share one generator, so a small set of distinct waveforms covers a large number of pins.

Software programs the block through a simple single-cycle register port. There is no back-pressure: every access completes in the cycle it is presented, and read data appears on `bus_rdata` one clock later. Writes carry a byte-enable mask, so one generator field or one pair of channel nibbles can be changed without a read-modify-write of its neighbours. Generator changes are buffered until the running period ends. Mapping changes act at once, except that disabling a channel waits for the end of the current high pulse.

Top module: `pwm_share_ctrl`

## Requirements
- R1: After reset every output pin and serial value is 0, and every register reads 0.
- R2: A write updates only the byte lanes whose `bus_be` bit is 1, and a read of the same address returns the merged word one clock after it is presented. Any address that is not one of the eleven word-aligned registers below reads 0, and writing it changes nothing.
- R3: Field positions are fixed. The period of generator g is byte g%4 of the word at 0x98+4*(g/4). The duty pair of generator g is halfword g%2 of the word at 0x3C+4*(g/2), with the on-count in its low byte and the off-count in its high byte. The nibble of channel c is bits [4*(c%8)+3 : 4*(c%8)] of the word at 0x4C+4*(c/8): its bits [2:0] select the generator and bit 3 enables the channel.
- R4: A prescaler emits one duty step every TICK_DIV clocks (default 2). A running generator repeats a unit of on-count steps high followed by off-count steps low, so the unit length is on+off steps. One period is `period` consecutive units. With off = 255 - on, the high time is on*TICK_DIV clocks and the unit repeats every 255*TICK_DIV clocks.
- R5: An on-count of 0 gives a constant low output. An on-count of 255 with an off-count of 0 gives a constant high output.
- R6: New period and duty values reach a running generator only after its current period has finished, so a change made in the first unit of a 3-unit period first shows in the fourth unit. A generator whose active period is 0 is idle: its output is low and it picks up the register values on every step.
- R7: Clearing a channel's enable bit never shortens a high pulse. The channel keeps following its generator until that generator is low, and then it holds 0.
- R8: A disabled channel drives 0 whatever its generator does. Setting the enable bit takes effect one clock after the write.
- R9: Changing an enabled channel's generator select changes its output in the clock right after the write.
- R10: All channels mapped to the same generator carry identical waveforms.
- R11: Channel c drives `pwm_direct[c]` for c below 16 and `pwm_serial[c-16]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of a 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write mask |
| bus_rdata | output | 32 | Read data, valid the clock after a read strobe |
| pwm_direct | output | 16 | Channels 0 to 15 |
| pwm_serial | output | 17 | Channels 16 to 32, levels for the serial stage |

## Verification
The assertions assume that reset is applied before any traffic and that a generator's duty pair is written before its period leaves 0. This ordering ensures that the first loaded period already carries the intended on-count. They also assume that the select field names an existing generator. The stimulus keeps to this: for each generator it writes the duty pair, then a nonzero period. It idles a generator by writing period 0 and waiting a full period before loading it again. It draws random on-counts only from 1 to 254, and random register data only at legal word addresses. Unmapped and misaligned addresses are used only in directed accesses.

// File: rtl/pwmshare_pkg.sv
package pwmshare_pkg;
  localparam int BUS_DW    = 32;
  localparam int BUS_AW    = 8;
  localparam int DUTY_BASE = 'h3C;
  localparam int MAP_BASE  = 'h4C;
  localparam int PER_BASE  = 'h98;
  localparam int NIB_W     = 4;
  localparam int STEP_W    = 9;
endpackage

// File: rtl/pwmshare_tick.sv
module pwmshare_tick #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == CW'(TICK_DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(TICK_DIV - 1));

      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pwmshare_wavegen.sv
module pwmshare_wavegen
  import pwmshare_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cfg_period,
  input  logic [7:0] cfg_on,
  input  logic [7:0] cfg_off,
  output logic       wave_o
);
  logic [7:0]        act_per, act_on, act_off, unit_cnt;
  logic [STEP_W-1:0] step_cnt, unit_len;
  logic              idle, unit_end, per_end;

  assign unit_len = {1'b0, act_on} + {1'b0, act_off};
  assign idle     = (act_per == 8'd0) || (unit_len == '0);
  assign unit_end = (step_cnt == unit_len - 1'b1);
  assign per_end  = unit_end && (unit_cnt == act_per - 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_per  <= '0;
      act_on   <= '0;
      act_off  <= '0;
      unit_cnt <= '0;
      step_cnt <= '0;
    end else if (tick) begin
      if (idle || per_end) begin
        act_per  <= cfg_period;
        act_on   <= cfg_on;
        act_off  <= cfg_off;
        unit_cnt <= '0;
        step_cnt <= '0;
      end else if (unit_end) begin
        unit_cnt <= unit_cnt + 8'd1;
        step_cnt <= '0;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  assign wave_o = !idle && (step_cnt < {1'b0, act_on});

  a_r4_step_in_unit: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (step_cnt < unit_len));
  a_r4_rise_at_unit_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_o) |-> (step_cnt == '0));
  a_r5_full_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && act_on == 8'hFF && act_off == 8'h00) |-> wave_o);
  a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !(tick && per_end)) |=> (act_on == $past(act_on) && act_per == $past(act_per)));
endmodule

// File: rtl/pwmshare_chan.sv
module pwmshare_chan #(
  parameter int NUM_GEN = 8,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GEN-1:0] gen_wave,
  input  logic [SEL_W-1:0]   sel,
  input  logic               en,
  output logic               pin
);
  logic live_q, picked;

  assign picked = gen_wave[sel];

  always_ff @(posedge clk) begin
    if (!rst_n)       live_q <= 1'b0;
    else if (en)      live_q <= 1'b1;
    else if (!picked) live_q <= 1'b0;
  end

  assign pin = live_q & picked;

  a_r7_drop_only_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live_q) |-> !$past(picked));
  a_r8_enable_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> live_q);
endmodule

// File: rtl/pwmshare_regbank.sv
module pwmshare_regbank
  import pwmshare_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 33
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_en,
  input  logic                         bus_we,
  input  logic [BUS_AW-1:0]            bus_addr,
  input  logic [BUS_DW-1:0]            bus_wdata,
  input  logic [3:0]                   bus_be,
  output logic [BUS_DW-1:0]            bus_rdata,
  output logic [NUM_GEN-1:0][7:0]      per_o,
  output logic [NUM_GEN-1:0][7:0]      on_o,
  output logic [NUM_GEN-1:0][7:0]      off_o,
  output logic [NUM_CH-1:0][NIB_W-1:0] nib_o
);
  localparam int DUTY_WORDS = (NUM_GEN + 1) / 2;
  localparam int PER_WORDS  = (NUM_GEN + 3) / 4;
  localparam int MAP_WORDS  = (NUM_CH + 7) / 8;

  logic [DUTY_WORDS-1:0][BUS_DW-1:0] duty_q;
  logic [PER_WORDS-1:0][BUS_DW-1:0]  per_q;
  logic [MAP_WORDS-1:0][BUS_DW-1:0]  map_q;
  logic [BUS_DW-1:0]                 rd_val;
  logic                              hit;

  function automatic logic [BUS_DW-1:0] lane_merge(
    input logic [BUS_DW-1:0] old_w, input logic [BUS_DW-1:0] new_w, input logic [3:0] be);
    logic [BUS_DW-1:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

  always_comb begin
    rd_val = '0;
    hit    = 1'b0;
    for (int i = 0; i < DUTY_WORDS; i++)
      if (bus_addr == BUS_AW'(DUTY_BASE + 4*i)) begin rd_val = duty_q[i]; hit = 1'b1; end
    for (int i = 0; i < PER_WORDS; i++)
      if (bus_addr == BUS_AW'(PER_BASE + 4*i)) begin rd_val = per_q[i]; hit = 1'b1; end
    for (int i = 0; i < MAP_WORDS; i++)
      if (bus_addr == BUS_AW'(MAP_BASE + 4*i)) begin rd_val = map_q[i]; hit = 1'b1; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q    <= '0;
      per_q     <= '0;
      map_q     <= '0;
      bus_rdata <= '0;
    end else if (bus_en) begin
      if (bus_we) begin
        for (int i = 0; i < DUTY_WORDS; i++)
          if (bus_addr == BUS_AW'(DUTY_BASE + 4*i)) duty_q[i] <= lane_merge(duty_q[i], bus_wdata, bus_be);
        for (int i = 0; i < PER_WORDS; i++)
          if (bus_addr == BUS_AW'(PER_BASE + 4*i)) per_q[i] <= lane_merge(per_q[i], bus_wdata, bus_be);
        for (int i = 0; i < MAP_WORDS; i++)
          if (bus_addr == BUS_AW'(MAP_BASE + 4*i)) map_q[i] <= lane_merge(map_q[i], bus_wdata, bus_be);
      end else begin
        bus_rdata <= rd_val;
      end
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_fields
    assign per_o[g] = per_q[g/4][8*(g%4) +: 8];
    assign on_o[g]  = duty_q[g/2][16*(g%2) +: 8];
    assign off_o[g] = duty_q[g/2][16*(g%2) + 8 +: 8];
  end
  for (genvar c = 0; c < NUM_CH; c++) begin : g_nibs
    assign nib_o[c] = map_q[c/8][NIB_W*(c%8) +: NIB_W];
  end

  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !hit) |=> (bus_rdata == '0));
endmodule

// File: rtl/pwm_share_ctrl.sv
module pwm_share_ctrl
  import pwmshare_pkg::*;
#(
  parameter int NUM_GEN    = 8,
  parameter int NUM_DIRECT = 16,
  parameter int NUM_SERIAL = 17,
  parameter int TICK_DIV   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [BUS_AW-1:0]     bus_addr,
  input  logic [BUS_DW-1:0]     bus_wdata,
  input  logic [3:0]            bus_be,
  output logic [BUS_DW-1:0]     bus_rdata,
  output logic [NUM_DIRECT-1:0] pwm_direct,
  output logic [NUM_SERIAL-1:0] pwm_serial
);
  localparam int NUM_CH = NUM_DIRECT + NUM_SERIAL;
  localparam int SEL_W  = $clog2(NUM_GEN);

  logic [NUM_GEN-1:0][7:0]      per_w, on_w, off_w;
  logic [NUM_CH-1:0][NIB_W-1:0] nib_w;
  logic [NUM_GEN-1:0]           wave;
  logic [NUM_CH-1:0]            pins;
  logic                         tick;

  pwmshare_regbank #(.NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .per_o(per_w), .on_o(on_w), .off_o(off_w), .nib_o(nib_w));

  pwmshare_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    pwmshare_wavegen u_wave (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cfg_period(per_w[g]), .cfg_on(on_w[g]), .cfg_off(off_w[g]), .wave_o(wave[g]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmshare_chan #(.NUM_GEN(NUM_GEN), .SEL_W(SEL_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .gen_wave(wave),
      .sel(nib_w[c][SEL_W-1:0]), .en(nib_w[c][NIB_W-1]), .pin(pins[c]));
  end

  assign pwm_direct = pins[NUM_DIRECT-1:0];
  assign pwm_serial = pins[NUM_CH-1:NUM_DIRECT];

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (pwm_direct == '0 && pwm_serial == '0));
endmodule

// File: tb/test_pwm_share_ctrl.sv
module test_pwm_share_ctrl;
  localparam int D = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pwm_direct;
  logic [16:0] pwm_serial;

  int vectors = 0, fails = 0;
  longint cyc = 0;
  logic [31:0] mdl [64];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_share_ctrl #(.TICK_DIV(D)) i_pwm_share_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .pwm_direct(pwm_direct), .pwm_serial(pwm_serial));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return (a[1:0] == 2'b00) &&
           ((a >= 8'h3C && a <= 8'h5C) || a == 8'h98 || a == 8'h9C);
  endfunction

  function automatic logic [7:0] reg_addr(input int i);
    if (i < 9) return 8'(8'h3C + 4*i);
    return 8'(8'h98 + 4*(i-9));
  endfunction

  function automatic bit chpin(input int c);
    return (c < 16) ? pwm_direct[c] : pwm_serial[c-16];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (mapped(a))
      for (int b = 0; b < 4; b++)
        if (be[b]) mdl[a[7:2]][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_duty(input int g, input int on);
    logic [31:0] w;
    w = 32'({8'(255 - on), 8'(on)}) << (16*(g%2));
    wr(8'(8'h3C + 4*(g/2)), w, 4'(4'b0011 << (2*(g%2))));
  endtask

  task automatic set_period(input int g, input int p);
    wr(8'(8'h98 + 4*(g/4)), 32'(p) << (8*(g%4)), 4'(1 << (g%4)));
  endtask

  task automatic set_map(input int c, input int g, input bit en);
    logic [7:0]  a;
    logic [31:0] w;
    a = 8'(8'h4C + 4*(c/8));
    w = mdl[a[7:2]];
    w[4*(c%8) +: 4] = {en, 3'(g)};
    wr(a, w, 4'(1 << ((c%8)/2)));
  endtask

  task automatic wait_level(input int c, input bit lvl);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (chpin(c) == lvl) return;
    end
  endtask

  task automatic count_high(input int c, input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (chpin(c)) highs++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int on_g [8];
    longint t0, t1, t2, t4;
    int highs, diffs;
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(pwm_direct == '0 && pwm_serial == '0, "R1", "pins after reset", {pwm_serial, pwm_direct}, 0);
    rd(8'h3C, r); chk(r == 0, "R1", "duty reg", r, 0);
    rd(8'h98, r); chk(r == 0, "R1", "period reg", r, 0);
    rd(8'h5C, r); chk(r == 0, "R1", "map reg", r, 0);

    // R4 random on-counts on every generator, one channel each (R11 on serial ones)
    for (int g = 0; g < 8; g++) begin
      on_g[g] = 1 + int'($urandom % 254);
      set_duty(g, on_g[g]);
      set_period(g, 1);
      set_map(g*4, g, 1'b1);
    end
    set_map(32, 3, 1'b1);
    for (int g = 0; g < 8; g++) begin
      wait_level(g*4, 0); wait_level(g*4, 1); t0 = cyc;
      wait_level(g*4, 0); t1 = cyc;
      wait_level(g*4, 1); t2 = cyc;
      chk(t1 - t0 == on_g[g]*D, "R4", "high time", t1 - t0, on_g[g]*D);
      chk(t2 - t0 == 255*D, "R4", "unit period", t2 - t0, 255*D);
    end
    wait_level(32, 0); wait_level(32, 1); t0 = cyc; wait_level(32, 0); t1 = cyc;
    chk(t1 - t0 == on_g[3]*D, "R11", "serial channel 32 high time", t1 - t0, on_g[3]*D);

    // R10 two channels on one generator
    set_map(5, 2, 1'b1); set_map(20, 2, 1'b1);
    repeat (4) @(negedge clk);
    diffs = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (pwm_direct[5] != pwm_serial[4]) diffs++;
    end
    chk(diffs == 0, "R10", "shared generator mismatched samples", diffs, 0);

    // R5 constant low, constant high (gen 6 on channel 24)
    set_duty(6, 0);
    repeat (1200) @(negedge clk);
    count_high(24, 600, highs);
    chk(highs == 0, "R5", "on-count 0 high samples", highs, 0);
    set_duty(6, 255);
    repeat (1200) @(negedge clk);
    count_high(24, 600, highs);
    chk(highs == 600, "R5", "on-count 255 high samples", highs, 600);

    // R6 deferred update within a 3-unit period
    set_period(7, 0);
    repeat (1200) @(negedge clk);
    set_map(31, 7, 1'b1);
    set_duty(7, 60);
    set_period(7, 3);
    wait_level(31, 1); t0 = cyc;
    set_duty(7, 150);
    wait_level(31, 0);
    wait_level(31, 1); t1 = cyc; wait_level(31, 0); t2 = cyc;
    chk(t2 - t1 == 60*D, "R6", "second unit keeps old duty", t2 - t1, 60*D);
    wait_level(31, 1); t1 = cyc; wait_level(31, 0); t2 = cyc;
    chk(t2 - t1 == 60*D, "R6", "third unit keeps old duty", t2 - t1, 60*D);
    wait_level(31, 1); t4 = cyc; wait_level(31, 0); t2 = cyc;
    chk(t2 - t4 == 150*D, "R6", "new duty after period end", t2 - t4, 150*D);
    chk(t4 - t0 == 3*255*D, "R6", "period of 3 units", t4 - t0, 3*255*D);

    // R7 disable during a high pulse completes the pulse
    set_duty(1, 200);
    repeat (1200) @(negedge clk);
    wait_level(4, 0); wait_level(4, 1); t0 = cyc;
    repeat (10) @(negedge clk);
    set_map(4, 1, 1'b0);
    wait_level(4, 0); t1 = cyc;
    chk(t1 - t0 == 200*D, "R7", "pulse width across disable", t1 - t0, 200*D);
    // R8 disabled channel stays low
    count_high(4, 1200, highs);
    chk(highs == 0, "R8", "disabled channel high samples", highs, 0);
    set_map(4, 1, 1'b1);
    wait_level(4, 0);
    set_map(4, 1, 1'b0);
    chk(chpin(4) == 0, "R8", "disable while low", chpin(4), 0);

    // R9 select change is immediate (gen 6 high, gen 0 low)
    set_duty(0, 0);
    repeat (1200) @(negedge clk);
    set_map(9, 6, 1'b1);
    repeat (3) @(negedge clk);
    chk(chpin(9) == 1, "R9", "select high generator", chpin(9), 1);
    set_map(9, 0, 1'b1);
    chk(chpin(9) == 0, "R9", "switch to low generator", chpin(9), 0);
    set_map(9, 6, 1'b1);
    chk(chpin(9) == 1, "R9", "switch back", chpin(9), 1);

    // R2 unmapped and misaligned addresses
    wr(8'h60, 32'hDEADBEEF, 4'hF); rd(8'h60, r);
    chk(r == 0, "R2", "unmapped read", r, 0);
    rd(8'h3D, r);
    chk(r == 0, "R2", "misaligned read", r, 0);

    // R3 byte lane of generator 6 period
    wr(8'h9C, 32'h00AB0000, 4'b0100); rd(8'h9C, r);
    chk(r[23:16] == 8'hAB, "R3", "period of generator 6 in byte 2", r[23:16], 8'hAB);
    chk(r == mdl[8'h9C >> 2], "R3", "other lanes kept", r, mdl[8'h9C >> 2]);

    // R2 random masked writes with readback
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      a = reg_addr(int'($urandom % 11));
      wr(a, $urandom, 4'($urandom % 16));
      rd(a, r);
      chk(r == mdl[a[7:2]], "R2", "masked readback", r, mdl[a[7:2]]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule